// File: doc/BRIEF.md
# Write-Protected SPI Register Slave

This block is the host-facing control port of a small power-management controller. A host talks to it over a four-wire serial link in SPI mode 0, most significant bit first, and every transaction is exactly 32 serial clocks long while chip select is held low. The first 12 bits are a command that carries a register address and a direction flag. The next 16 bits are the data word: the host shifts it in on a write, and the slave shifts out the addressed register on a read. The last 4 bits are a status nibble that the slave returns. It reports whether the frame length was correct, which direction was decoded, whether the address was bad, and whether a write was refused.

Register contents leave the block on a flat parallel bus so that the regulator, alarm and interrupt logic elsewhere on the chip can use them. Writes to ordinary registers only take effect while a lock register holds exactly 1. Software opens the lock, performs a read-modify-write, and then closes the lock again. A write to the software-reset address clears every register, including the lock. All serial inputs are resynchronised to the system clock before use, so the serial clock must be several times slower than the system clock.

Top module: `pmic_spi_regslave`

## Requirements
- R1: A read frame has command bit 5 = 0 and the address in command bits [9:6]. It returns the addressed 16-bit register on MISO during data clocks 13 to 28, MSB first. MISO changes on falling SCLK and is sampled by the host on rising SCLK.
- R2: A write frame has command bit 5 = 1. It updates a storage register (0x0 to 0x7) with the 16-bit data word, which is then visible on `reg_vals` and to later reads, provided the lock register holds 1.
- R3: While the lock register holds any value other than 1, a write to a valid address other than 0xD leaves the register unchanged and sets status bit 0.
- R4: Address 0xD is the lock register. Writes to it are always applied, and the lock counts as open only when its value equals exactly 1.
- R5: Status bit 3 is 1 on every complete 32-clock frame. Status bit 2 echoes the decoded direction (1 = write). The nibble is sent MSB first on clocks 29 to 32.
- R6: Addresses 0x8, 0x9, 0xA, 0xC and 0xE are invalid. For these, status bit 1 is set, reads return 0, writes change nothing, and status bit 0 stays 0.
- R7: Address 0xF reads the REV_ID parameter. A write to it is refused with status bit 1 set and changes nothing.
- R8: An applied write of any value to 0xB clears all registers to 0, including the lock, two system clocks after the frame's last rising SCLK is seen. If the lock is closed, the write is refused as in R3.
- R9: If chip select rises before the 32nd rising SCLK, the frame is aborted. No register changes, and the next frame decodes normally.
- R10: After reset, all registers read 0, `reg_vals` holds 0 in every slot except slot 15 (REV_ID), and MISO is 0.
- R11: The sequence unlock, read, write, relock runs back to back and leaves the modified value in place with the lock closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_vals | output | 256 | All 16 register slots, slot n at bits [16n+15:16n] |

## Verification
The assertions take for granted two things about the inputs. First, the serial clock is slow enough that every level lasts longer than the synchroniser delay. Second, MOSI is stable around each rising SCLK edge, so an edge seen after synchronisation always pairs with the intended data bit. The stimulus keeps each SCLK half period at six system clocks, changes MOSI only while SCLK is low, and holds chip select high for several system clocks between frames. As a result, frame boundaries and edges are never merged by the synchroniser. Aborted frames raise chip select only while SCLK is low, which matches the way a host ends a transfer early.

// File: rtl/pmic_spi_pkg.sv
package pmic_spi_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 4;
    localparam int CMD_W     = 12;
    localparam int STAT_W    = 4;
    localparam int FRAME_LEN = CMD_W + DATA_W + STAT_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int ADDR_LSB  = 6;
    localparam int WR_BIT    = 5;

    localparam logic [ADDR_W-1:0] A_LAST_PLAIN = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_SRST       = ADDR_W'(11);
    localparam logic [ADDR_W-1:0] A_LOCK       = ADDR_W'(13);
    localparam logic [ADDR_W-1:0] A_REV        = ADDR_W'(NUM_REGS - 1);

    typedef struct packed {
        logic len_ok;
        logic wr;
        logic bad_addr;
        logic locked_out;
    } stat_t;

    function automatic logic addr_valid(input logic [ADDR_W-1:0] a);
        return (a <= A_LAST_PLAIN) || (a == A_SRST) || (a == A_LOCK) || (a == A_REV);
    endfunction

    function automatic logic addr_stored(input logic [ADDR_W-1:0] a);
        return (a <= A_LAST_PLAIN) || (a == A_LOCK);
    endfunction

endpackage

// File: rtl/pmic_spi_sync.sv
module pmic_spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    assign chain_d[0] = din;

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign chain_d[g] = chain_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/pmic_spi_frame.sv
module pmic_spi_frame
    import pmic_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              csn_s,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              unlocked,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso
);

    localparam int               RX_W     = DATA_W - 1;
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_STAT = CNT_W'(CMD_W + DATA_W);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_LEN);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              sclk_prev;
        logic [RX_W-1:0]   rx;
        logic [DATA_W-1:0] tx;
        logic              miso;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] data;
        stat_t             stat;
        logic              commit;
    } frame_st_t;

    frame_st_t         d, q;
    logic [DATA_W-1:0] rx_n;
    logic              rise, fall;
    stat_t             st;

    // shift word including the bit present on this rising edge
    assign rx_n    = {q.rx, mosi_s};
    assign rd_addr = rx_n[ADDR_LSB+ADDR_W-1:ADDR_LSB];
    assign rise    = sclk_s & ~q.sclk_prev & ~csn_s;
    assign fall    = ~sclk_s & q.sclk_prev & ~csn_s;

    always_comb begin
        d           = q;
        d.commit    = 1'b0;
        d.sclk_prev = sclk_s;
        st          = q.stat;
        if (csn_s) begin
            d.cnt  = '0;
            d.miso = 1'b0;
        end else if (rise && q.cnt != CNT_END) begin
            d.rx  = rx_n[RX_W-1:0];
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_CMD - 1'b1) begin
                d.addr = rd_addr;
                d.wr   = rx_n[WR_BIT];
                d.tx   = rx_n[WR_BIT] ? '0 : rd_data;
            end
            if (q.cnt == CNT_STAT - 1'b1) begin
                d.data        = rx_n;
                st.len_ok     = 1'b1;
                st.wr         = q.wr;
                st.bad_addr   = !addr_valid(q.addr) || (q.wr && q.addr == A_REV);
                st.locked_out = q.wr && !st.bad_addr && (q.addr != A_LOCK) && !unlocked;
                d.stat        = st;
                d.tx          = {st, {(DATA_W-STAT_W){1'b0}}};
            end
            if (q.cnt == CNT_END - 1'b1) begin
                d.commit = q.wr && !q.stat.bad_addr && !q.stat.locked_out;
            end
        end else if (fall && q.cnt >= CNT_CMD && q.cnt != CNT_END) begin
            d.miso = q.tx[DATA_W-1];
            d.tx   = {q.tx[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_en   = q.commit;
    assign wr_addr = q.addr;
    assign wr_data = q.data;
    assign miso    = q.miso;

    AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |-> (q.cnt == CNT_END));  // R9
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (q.cnt == '0));  // R9
    AST_STATUS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt >= CNT_STAT) |-> q.stat.len_ok);  // R5
    AST_WR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |-> q.stat.wr);  // R5

endmodule

// File: rtl/pmic_spi_regfile.sv
module pmic_spi_regfile
    import pmic_spi_pkg::*;
#(
    parameter logic [DATA_W-1:0] REV_ID = 16'h0A31
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       unlocked,
    output logic [NUM_REGS*DATA_W-1:0] reg_vals
);

    localparam int MEM_N = NUM_REGS - 1;

    typedef struct packed {
        logic [MEM_N-1:0][DATA_W-1:0] mem;
        logic                         srst_pend;
    } rf_st_t;

    rf_st_t d, q;

    always_comb begin
        d           = q;
        d.srst_pend = 1'b0;
        if (q.srst_pend) begin
            d.mem = '0;
        end else if (wr_en) begin
            if (wr_addr == A_SRST)          d.srst_pend    = 1'b1;
            else if (addr_stored(wr_addr))  d.mem[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (rd_addr == A_REV)          rd_data = REV_ID;
        else if (addr_stored(rd_addr)) rd_data = q.mem[rd_addr];
        else                           rd_data = '0;
    end

    assign unlocked = (q.mem[A_LOCK] == DATA_W'(1));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        if (g == NUM_REGS - 1) begin : g_rev
            assign reg_vals[g*DATA_W +: DATA_W] = REV_ID;
        end else begin : g_mem
            assign reg_vals[g*DATA_W +: DATA_W] = q.mem[g];
        end
    end

    AST_LOCK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != A_LOCK) |-> unlocked);  // R3
    AST_NO_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (addr_valid(wr_addr) && wr_addr != A_REV));  // R6
    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        q.srst_pend |=> (q.mem == '0));  // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !q.srst_pend) |=> $stable(q.mem));  // R9

endmodule

// File: rtl/pmic_spi_regslave.sv
module pmic_spi_regslave
    import pmic_spi_pkg::*;
#(
    parameter logic [DATA_W-1:0] REV_ID      = 16'h0A31,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sclk,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    output logic [NUM_REGS*DATA_W-1:0] reg_vals
);

    logic              sclk_s, mosi_s, csn_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en, unlocked;

    pmic_spi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_mosi, spi_sclk}),
        .dout  ({csn_s, mosi_s, sclk_s})
    );

    pmic_spi_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .mosi_s   (mosi_s),
        .csn_s    (csn_s),
        .rd_data  (rd_data),
        .unlocked (unlocked),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .miso     (spi_miso)
    );

    pmic_spi_regfile #(
        .REV_ID (REV_ID)
    ) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .unlocked (unlocked),
        .reg_vals (reg_vals)
    );

endmodule

// File: tb/pmic_spi_regslave_bench.sv
module pmic_spi_regslave_bench;

    localparam logic [15:0] REV  = 16'h0A31;
    localparam int          HALF = 6;
    localparam int          NV   = 20;

    // {wr, addr, wdata, expected read data, expected status}
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 4'h3, 16'h0000, 16'h0000, 4'h8},
        {1'b1, 4'h2, 16'hA5A5, 16'h0000, 4'hD},
        {1'b0, 4'h2, 16'h0000, 16'h0000, 4'h8},
        {1'b1, 4'hD, 16'h0002, 16'h0000, 4'hC},
        {1'b1, 4'h2, 16'h1234, 16'h0000, 4'hD},
        {1'b1, 4'hD, 16'h0001, 16'h0000, 4'hC},
        {1'b1, 4'h2, 16'hBEEF, 16'h0000, 4'hC},
        {1'b0, 4'h2, 16'h0000, 16'hBEEF, 4'h8},
        {1'b1, 4'h7, 16'h8001, 16'h0000, 4'hC},
        {1'b0, 4'h7, 16'h0000, 16'h8001, 4'h8},
        {1'b1, 4'hD, 16'h0000, 16'h0000, 4'hC},
        {1'b1, 4'h7, 16'hFFFF, 16'h0000, 4'hD},
        {1'b0, 4'h7, 16'h0000, 16'h8001, 4'h8},
        {1'b0, 4'hF, 16'h0000, REV,      4'h8},
        {1'b1, 4'hF, 16'h0000, 16'h0000, 4'hE},
        {1'b0, 4'hF, 16'h0000, REV,      4'h8},
        {1'b0, 4'h9, 16'h0000, 16'h0000, 4'hA},
        {1'b0, 4'hE, 16'h0000, 16'h0000, 4'hA},
        {1'b1, 4'hC, 16'h1111, 16'h0000, 4'hE},
        {1'b0, 4'hD, 16'h0000, 16'h0000, 4'h8}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         mosi = 1'b0;
    logic         miso;
    logic [255:0] reg_vals;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    pmic_spi_regslave #(.REV_ID(REV)) u_pmic_spi_regslave (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (sclk),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_miso (miso),
        .reg_vals (reg_vals)
    );

    function automatic string vec_req(input int i);
        case (i)
            0:            return "R10";
            1, 2, 11, 12: return "R3";
            3, 4, 5, 10, 19: return "R4";
            6, 8:         return "R2";
            7, 9:         return "R1";
            13, 14, 15:   return "R7";
            default:      return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic spi_frame(input logic w, input logic [3:0] a, input logic [15:0] wd,
                             input int nclk, output logic [15:0] rd, output logic [3:0] st);
        logic [31:0] sh;
        sh = {2'b00, a, w, 5'b00000, wd, 4'b0000};
        rd = '0;
        st = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nclk; i++) begin
            mosi = sh[31-i];
            wait_clk(HALF);
            if (i >= 12 && i < 28) rd[27-i] = miso;
            else if (i >= 28)      st[31-i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(12);
    endtask

    function automatic logic [15:0] slot(input logic [255:0] v, input int n);
        return v[n*16 +: 16];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired (all requirements)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [3:0]  st;
        logic [15:0] nv;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R10: reset state at the ports
        check("R10 miso", {15'b0, miso}, 16'h0000);
        check("R10 slot15", slot(reg_vals, 15), REV);
        for (int k = 0; k < 15; k++) check("R10 slot", slot(reg_vals, k), 16'h0000);

        // table walk (R5 on each status nibble)
        for (int i = 0; i < NV; i++) begin
            spi_frame(VEC[i][40], VEC[i][39:36], VEC[i][35:20], 32, rd, st);
            check({"R5 ", vec_req(i), " status"}, {12'b0, st}, {12'b0, VEC[i][3:0]});
            if (!VEC[i][40]) check({"R1 ", vec_req(i), " data"}, rd, VEC[i][19:4]);
        end
        check("R2 slot2", slot(reg_vals, 2), 16'hBEEF);
        check("R6 slot12", slot(reg_vals, 12), 16'h0000);

        // R11: back-to-back unlock, read-modify-write, relock
        spi_frame(1'b1, 4'hD, 16'h0001, 32, rd, st);
        check("R11 unlock status", {12'b0, st}, 16'h000C);
        spi_frame(1'b0, 4'h2, 16'h0000, 32, rd, st);
        check("R11 read", rd, 16'hBEEF);
        nv = (rd & ~16'h00F0) | 16'h0030;
        spi_frame(1'b1, 4'h2, nv, 32, rd, st);
        check("R11 write status", {12'b0, st}, 16'h000C);
        spi_frame(1'b1, 4'hD, 16'h0000, 32, rd, st);
        check("R11 slot2", slot(reg_vals, 2), 16'hBE3F);
        check("R11 lock closed", slot(reg_vals, 13), 16'h0000);

        // R9: aborted frames change nothing
        spi_frame(1'b1, 4'hD, 16'h0001, 32, rd, st);
        spi_frame(1'b1, 4'h2, 16'h1111, 20, rd, st);
        check("R9 abort at 20", slot(reg_vals, 2), 16'hBE3F);
        spi_frame(1'b1, 4'h2, 16'h2222, 31, rd, st);
        check("R9 abort at 31", slot(reg_vals, 2), 16'hBE3F);
        spi_frame(1'b0, 4'h2, 16'h0000, 32, rd, st);
        check("R9 next frame data", rd, 16'hBE3F);
        check("R9 next frame status", {12'b0, st}, 16'h0008);

        // R8: software reset, refused while locked, applied while open
        spi_frame(1'b1, 4'h5, 16'hABCD, 32, rd, st);
        check("R8 slot5 set", slot(reg_vals, 5), 16'hABCD);
        spi_frame(1'b1, 4'hD, 16'h0000, 32, rd, st);
        spi_frame(1'b1, 4'hB, 16'h0000, 32, rd, st);
        check("R8 locked reset status", {12'b0, st}, 16'h000D);
        check("R8 locked reset no effect", slot(reg_vals, 5), 16'hABCD);
        spi_frame(1'b1, 4'hD, 16'h0001, 32, rd, st);
        spi_frame(1'b1, 4'hB, 16'h5A5A, 32, rd, st);
        check("R8 reset status", {12'b0, st}, 16'h000C);
        for (int k = 0; k < 15; k++) check("R8 slot cleared", slot(reg_vals, k), 16'h0000);
        check("R8 slot15", slot(reg_vals, 15), REV);
        spi_frame(1'b0, 4'hD, 16'h0000, 32, rd, st);
        check("R8 lock read", rd, 16'h0000);
        spi_frame(1'b1, 4'h5, 16'h7777, 32, rd, st);
        check("R8 lock cleared status", {12'b0, st}, 16'h000D);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule